// File: doc/BRIEF.md
# Quad-Lane PSRAM Transaction Engine

This block sits between an on-chip requester and a serial pseudo-static RAM that has already been switched into its four-lane command mode. A requester hands it one word-sized read or write, or a request to change the device's wrap length, through a valid/ready port. The engine then produces chip select, serial clock and the four data lanes for the whole transaction. It returns a single response pulse once chip select has been released.

Each serial clock period takes two system clocks. Lane data changes while the serial clock is low, and the device samples on the rising edge. Reads carry a dummy phase, of parameterised length, between the address and the returned data. Returned nibbles are collected into a word. The engine keeps track of the wrap length currently programmed into the device. It only sends the wrap-length command when a legal request asks for a different length. Illegal lengths are refused without any bus activity.

Top module: `qspi_ram_engine`

## Requirements
- R1: A read (req_op = 0) sends command byte 0xEB in 2 serial clocks, then the 24-bit address in 6 serial clocks, then DUMMY_CYC (default 6) dummy clocks, then captures 8 nibbles, giving 22 rising serial clock edges in total. The first captured nibble becomes rsp_rdata[31:28].
- R2: A write (req_op = 1) sends command byte 0x38, then the 24-bit address, then the 32 data bits directly with no dummy phase: 16 rising serial clock edges, all with the lanes driven.
- R3: Every byte and word leaves high nibble first, with bit 3 of a nibble on ram_dq_out[3]. Command, then address, then data are sent in this order.
- R4: ram_dq_oe is low on every rising serial clock edge from the first dummy clock until chip select is released, and whenever chip select is high.
- R5: A wrap request (req_op = 2) with req_wrap other than 0 or 32, and any request with req_op = 3, gets a response with rsp_err = 1, and chip select stays high.
- R6: A wrap request for 0 or 32 that differs from the stored length sends only command byte 0xC0 (2 serial clocks, no address, no data). The new length is stored when chip select is released. The stored length is 0 after reset.
- R7: A wrap request equal to the stored length responds with rsp_err = 0 and no bus transaction.
- R8: req_ready is high only when the engine is idle. It drops on acceptance and stays low until chip select has been released, so at most one request is in progress.
- R9: After reset: ram_cs_n = 1, ram_sck = 0, ram_dq_oe = 0, req_ready = 1, rsp_valid = 0.
- R10: Every request gets exactly one rsp_valid pulse, one cycle long, while chip select is high. Reads and writes report rsp_err = 0, and rsp_rdata is 0 for everything but reads.
- R11: ram_sck stays low while ram_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_op | input | 2 | 0 read, 1 write, 2 wrap length, 3 refused |
| req_addr | input | ADDR_W | Byte address for read/write |
| req_wdata | input | DATA_W | Write word |
| req_wrap | input | WRAP_W | Requested wrap length in bytes |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request refused |
| rsp_rdata | output | DATA_W | Read word |
| ram_cs_n | output | 1 | Chip select, active low |
| ram_sck | output | 1 | Serial clock |
| ram_dq_out | output | 4 | Lane output values |
| ram_dq_oe | output | 1 | Lane output enable |
| ram_dq_in | input | 4 | Lane input values |

## Verification
The assertions assume that the requester keeps req_op, req_addr, req_wdata and req_wrap stable in the cycle where req_valid meets req_ready. They also assume the device drives ram_dq_in only after a falling serial clock edge that follows the dummy phase. The bench raises req_valid only at a falling system clock edge after it has seen req_ready high, and drops it one cycle later. Its device model changes the lanes only on falling serial clock edges, counted from the rising edges it has seen since chip select fell.

// File: rtl/qpr_pkg.sv
package qpr_pkg;
  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_WRAP  = 2'd2;
  localparam logic [1:0] OP_BAD   = 2'd3;

  localparam logic [7:0] CMD_QREAD   = 8'hEB;
  localparam logic [7:0] CMD_QWRITE  = 8'h38;
  localparam logic [7:0] CMD_WRAPLEN = 8'hC0;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_TX, S_DUMMY, S_RX, S_HOLD, S_RESP
  } eng_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/qpr_lanes.sv
module qpr_lanes #(
  parameter int FRAME_W = 64,
  parameter int RX_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               shift,
  input  logic               cap,
  input  logic [3:0]         dq_in,
  output logic [3:0]         nib,
  output logic [RX_W-1:0]    rx_word
);
  logic [FRAME_W-1:0] frame_q;
  logic [RX_W-1:0]    rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      rx_q    <= '0;
    end else if (load) begin
      frame_q <= frame_in;
      rx_q    <= '0;
    end else begin
      if (shift) frame_q <= {frame_q[FRAME_W-5:0], 4'h0};
      if (cap)   rx_q    <= {rx_q[RX_W-5:0], dq_in};
    end
  end

  assign nib     = frame_q[FRAME_W-1 -: 4];
  assign rx_word = rx_q;
endmodule

// File: rtl/qpr_wrap_track.sv
module qpr_wrap_track #(
  parameter int SZ_W    = 8,
  parameter int LEGAL_A = 0,
  parameter int LEGAL_B = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SZ_W-1:0] probe_size,
  input  logic            commit,
  input  logic [SZ_W-1:0] commit_size,
  output logic            legal,
  output logic            differs
);
  logic [SZ_W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (rst) cur_q <= SZ_W'(LEGAL_A);
    else if (commit) cur_q <= commit_size;
  end

  assign legal   = (probe_size == SZ_W'(LEGAL_A)) || (probe_size == SZ_W'(LEGAL_B));
  assign differs = (probe_size != cur_q);

  AST_WRAP_STORED_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cur_q == SZ_W'(LEGAL_A)) || (cur_q == SZ_W'(LEGAL_B))); // R6
  AST_COMMIT_CHANGES: assert property (@(posedge clk) disable iff (rst)
    commit |-> (commit_size != cur_q)); // R7
endmodule

// File: rtl/qspi_ram_engine.sv
module qspi_ram_engine
  import qpr_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int WRAP_W    = 8,
  parameter int DUMMY_CYC = 6,
  parameter int CS_SETUP  = 0,
  parameter int CS_HOLD   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WRAP_W-1:0] req_wrap,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ram_cs_n,
  output logic              ram_sck,
  output logic [3:0]        ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [3:0]        ram_dq_in
);
  localparam int CMD_W   = 8;
  localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;
  localparam int CMD_NIB = CMD_W / 4;
  localparam int RD_NIB  = (CMD_W + ADDR_W) / 4;
  localparam int WR_NIB  = FRAME_W / 4;
  localparam int RX_NIB  = DATA_W / 4;
  localparam int MAXC    = imax(imax(WR_NIB, DUMMY_CYC), imax(CS_SETUP, CS_HOLD)) + 1;
  localparam int CNT_W   = $clog2(MAXC + 1);

  eng_state_e         st;
  logic [CNT_W-1:0]   cnt, tx_n;
  logic               half, has_rx, is_wrap;
  logic [WRAP_W-1:0]  pend_size;
  logic               cs_n_q, sck_q, oe_q, err_q;
  logic [3:0]         dq_q;

  logic               accept, lane_load, lane_shift, lane_cap;
  logic [FRAME_W-1:0] frame_in;
  logic [3:0]         nib;
  logic [DATA_W-1:0]  rx_word;
  logic               wrap_legal, wrap_differs, wrap_commit, refuse;

  assign accept = (st == S_IDLE) && req_valid;

  always_comb begin
    case (req_op)
      OP_READ:  frame_in = {CMD_QREAD, req_addr, {DATA_W{1'b0}}};
      OP_WRITE: frame_in = {CMD_QWRITE, req_addr, req_wdata};
      default:  frame_in = {CMD_WRAPLEN, {(ADDR_W + DATA_W){1'b0}}};
    endcase
  end

  assign refuse      = (req_op == OP_BAD) || ((req_op == OP_WRAP) && !wrap_legal);
  assign lane_load   = accept;
  assign lane_shift  = (st == S_TX) && half;
  assign lane_cap    = (st == S_RX) && half;
  assign wrap_commit = (st == S_HOLD) && (cnt == '0) && is_wrap;

  qpr_lanes #(.FRAME_W(FRAME_W), .RX_W(DATA_W)) i_lanes (
    .clk(clk), .rst(rst), .load(lane_load), .frame_in(frame_in),
    .shift(lane_shift), .cap(lane_cap), .dq_in(ram_dq_in),
    .nib(nib), .rx_word(rx_word)
  );

  qpr_wrap_track #(.SZ_W(WRAP_W), .LEGAL_A(0), .LEGAL_B(32)) i_wrap (
    .clk(clk), .rst(rst), .probe_size(req_wrap), .commit(wrap_commit),
    .commit_size(pend_size), .legal(wrap_legal), .differs(wrap_differs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      tx_n      <= '0;
      half      <= 1'b0;
      has_rx    <= 1'b0;
      is_wrap   <= 1'b0;
      pend_size <= '0;
      cs_n_q    <= 1'b1;
      sck_q     <= 1'b0;
      oe_q      <= 1'b0;
      dq_q      <= 4'h0;
      err_q     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          half <= 1'b0;
          if (req_valid) begin
            err_q     <= 1'b0;
            has_rx    <= (req_op == OP_READ);
            is_wrap   <= (req_op == OP_WRAP);
            pend_size <= req_wrap;
            cnt       <= CNT_W'(CS_SETUP);
            if (refuse) begin
              err_q <= 1'b1;
              st    <= S_RESP;
            end else if ((req_op == OP_WRAP) && !wrap_differs) begin
              st <= S_RESP;
            end else begin
              cs_n_q <= 1'b0;
              st     <= S_SETUP;
              case (req_op)
                OP_READ:  tx_n <= CNT_W'(RD_NIB);
                OP_WRITE: tx_n <= CNT_W'(WR_NIB);
                default:  tx_n <= CNT_W'(CMD_NIB);
              endcase
            end
          end
        end
        S_SETUP: begin
          if (cnt == '0) st <= S_TX;
          else cnt <= cnt - 1'b1;
        end
        S_TX: begin
          if (!half) begin
            sck_q <= 1'b0;
            oe_q  <= 1'b1;
            dq_q  <= nib;
            half  <= 1'b1;
          end else begin
            sck_q <= 1'b1;
            half  <= 1'b0;
            if (tx_n == CNT_W'(1)) begin
              if (has_rx) begin
                st  <= (DUMMY_CYC == 0) ? S_RX : S_DUMMY;
                cnt <= (DUMMY_CYC == 0) ? CNT_W'(RX_NIB) : CNT_W'(DUMMY_CYC);
              end else begin
                st  <= S_HOLD;
                cnt <= CNT_W'(CS_HOLD);
              end
            end else begin
              tx_n <= tx_n - 1'b1;
            end
          end
        end
        S_DUMMY: begin
          if (!half) begin
            sck_q <= 1'b0;
            oe_q  <= 1'b0;
            half  <= 1'b1;
          end else begin
            sck_q <= 1'b1;
            half  <= 1'b0;
            if (cnt == CNT_W'(1)) begin
              st  <= S_RX;
              cnt <= CNT_W'(RX_NIB);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        S_RX: begin
          if (!half) begin
            sck_q <= 1'b0;
            oe_q  <= 1'b0;
            half  <= 1'b1;
          end else begin
            sck_q <= 1'b1;
            half  <= 1'b0;
            if (cnt == CNT_W'(1)) begin
              st  <= S_HOLD;
              cnt <= CNT_W'(CS_HOLD);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        S_HOLD: begin
          sck_q <= 1'b0;
          oe_q  <= 1'b0;
          if (cnt == '0) begin
            cs_n_q <= 1'b1;
            st     <= S_RESP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign rsp_valid  = (st == S_RESP);
  assign rsp_err    = err_q;
  assign rsp_rdata  = has_rx ? rx_word : '0;
  assign ram_cs_n   = cs_n_q;
  assign ram_sck    = sck_q;
  assign ram_dq_out = dq_q;
  assign ram_dq_oe  = oe_q;

  AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ram_cs_n && !ram_sck)); // R8
  AST_RX_LANES_FREE: assert property (@(posedge clk) disable iff (rst)
    (st == S_RX) |-> !ram_dq_oe); // R4
  AST_CS_HIGH_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    ram_cs_n |-> !ram_dq_oe); // R4
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10
  AST_RSP_CS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ram_cs_n); // R10
  AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    ram_cs_n |-> !ram_sck); // R11
  AST_REFUSE_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    (accept && refuse) |=> (ram_cs_n && rsp_err)); // R5
endmodule

// File: tb/test_qspi_ram_engine.sv
`timescale 1ns/1ps
module test_qspi_ram_engine;
  localparam int D = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  req_wrap = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        ram_cs_n, ram_sck, ram_dq_oe;
  logic [3:0]  ram_dq_out;
  logic [3:0]  ram_dq_in = 4'h0;

  always #2.5 clk = ~clk;

  qspi_ram_engine i_qspi_ram_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_wrap(req_wrap),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ram_cs_n(ram_cs_n), .ram_sck(ram_sck), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [23:0] a);
    return {a[15:0], a[23:8]} ^ 32'hA5C3_0F96;
  endfunction

  // scoreboard queues
  logic [32:0] exp_rsp[$];   // {err, data}
  int          exp_rise[$];
  int          exp_txn[$];
  logic [63:0] exp_bits[$];
  int          exp_frames = 0;

  // device model
  int          rise_cnt, tx_cnt, frames_seen = 0;
  logic [63:0] tx_bits;
  logic [31:0] rd_word;
  bit          oe_late, frame_open = 1'b0;
  int          ready_busy = 0, sck_idle_bad = 0;

  always @(negedge ram_cs_n) begin
    rise_cnt = 0; tx_cnt = 0; tx_bits = '0; oe_late = 1'b0; frame_open = 1'b1;
    ready_busy = 0;
  end

  always @(posedge ram_sck) begin
    if (ram_dq_oe) begin
      if (rise_cnt > tx_cnt) oe_late = 1'b1;
      tx_bits = {tx_bits[59:0], ram_dq_out};
      tx_cnt++;
    end
    rise_cnt++;
    if (rise_cnt == 8) rd_word = mem_word(tx_bits[23:0]);
  end

  always @(negedge ram_sck) begin
    if (!ram_cs_n && rise_cnt >= 8 + D && rise_cnt < 16 + D)
      ram_dq_in = rd_word[31 - 4*(rise_cnt - 8 - D) -: 4];
  end

  always @(negedge clk) begin
    if (!rst && !ram_cs_n && req_ready) ready_busy++;
    if (!rst && ram_cs_n && ram_sck) sck_idle_bad++;
  end

  // bus monitor
  always @(posedge ram_cs_n) begin
    if (frame_open) begin
      frame_open = 1'b0;
      frames_seen++;
      if (exp_rise.size() == 0) begin
        chk(1'b0, "R5/R7 unexpected bus frame", 64'(rise_cnt), 64'd0);
      end else begin
        int er, et;
        logic [63:0] eb;
        er = exp_rise.pop_front(); et = exp_txn.pop_front(); eb = exp_bits.pop_front();
        chk(rise_cnt == er, "R1/R2/R6 rising sck count", 64'(rise_cnt), 64'(er));
        chk(tx_cnt == et, "R2/R6 driven nibble count", 64'(tx_cnt), 64'(et));
        chk(tx_bits == eb, "R3 command/address/data bits", tx_bits, eb);
        chk(!oe_late, "R4 lanes released after dummy start", 64'(oe_late), 64'd0);
        chk(ready_busy == 0, "R8 ready low while busy", 64'(ready_busy), 64'd0);
      end
    end
  end

  // response monitor
  bit prev_rsp = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_rsp && rsp_valid) chk(1'b0, "R10 response longer than one cycle", 64'd1, 64'd0);
      if (rsp_valid) begin
        if (exp_rsp.size() == 0) begin
          chk(1'b0, "R10 unexpected response", 64'(rsp_rdata), 64'd0);
        end else begin
          logic [32:0] e;
          e = exp_rsp.pop_front();
          chk(rsp_err == e[32], "R5/R7/R10 rsp_err", 64'(rsp_err), 64'(e[32]));
          chk(rsp_rdata == e[31:0], "R1/R10 rsp_rdata", 64'(rsp_rdata), 64'(e[31:0]));
          chk(ram_cs_n, "R10 response after cs release", 64'(ram_cs_n), 64'd1);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [23:0] a, input logic [31:0] wd, input logic [7:0] wsz);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_wdata = wd; req_wrap = wsz; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [23:0] a);  // R1
    exp_rsp.push_back({1'b0, mem_word(a)});
    exp_rise.push_back(16 + D); exp_txn.push_back(8);
    exp_bits.push_back({32'h0, 8'hEB, a}); exp_frames++;
    issue(2'd0, a, 32'h0, 8'h0);
  endtask

  task automatic do_write(input logic [23:0] a, input logic [31:0] d);  // R2
    exp_rsp.push_back({1'b0, 32'h0});
    exp_rise.push_back(16); exp_txn.push_back(16);
    exp_bits.push_back({8'h38, a, d}); exp_frames++;
    issue(2'd1, a, d, 8'h0);
  endtask

  task automatic do_wrap(input logic [7:0] s, input bit bus, input bit err);  // R5 R6 R7
    exp_rsp.push_back({err, 32'h0});
    if (bus) begin
      exp_rise.push_back(2); exp_txn.push_back(2);
      exp_bits.push_back(64'h00000000_000000C0); exp_frames++;
    end
    issue(2'd2, 24'h0, 32'h0, s);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(ram_cs_n == 1'b1, "R9 cs_n after reset", 64'(ram_cs_n), 64'd1);
    chk(ram_sck == 1'b0, "R9 sck after reset", 64'(ram_sck), 64'd0);
    chk(ram_dq_oe == 1'b0, "R9 oe after reset", 64'(ram_dq_oe), 64'd0);
    chk(req_ready == 1'b1, "R9 ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R9 rsp_valid after reset", 64'(rsp_valid), 64'd0);

    do_wrap(8'd0, 1'b0, 1'b0);    // R7 equal to reset length
    do_wrap(8'd32, 1'b1, 1'b0);   // R6 change
    do_wrap(8'd32, 1'b0, 1'b0);   // R7 same again
    do_wrap(8'd16, 1'b0, 1'b1);   // R5
    do_wrap(8'd64, 1'b0, 1'b1);   // R5
    do_wrap(8'd7, 1'b0, 1'b1);    // R5
    exp_rsp.push_back({1'b1, 32'h0});
    issue(2'd3, 24'h123456, 32'h0, 8'd32);  // R5 op 3 refused
    do_wrap(8'd0, 1'b1, 1'b0);    // R6 back to 0
    do_write(24'h123456, 32'hDEADBEEF);
    do_read(24'h123456);
    do_read(24'hFFFFFF);
    do_write(24'h000000, 32'h0F1E2D3C);
    do_read(24'h000000);
    do_read(24'hA5015A);
    do_wrap(8'd0, 1'b0, 1'b0);    // R7

    for (int i = 0; i < 200 && (exp_rsp.size() != 0 || !req_ready); i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_rsp.size() == 0, "R10 all responses seen", 64'(exp_rsp.size()), 64'd0);
    chk(frames_seen == exp_frames, "R5/R7 bus frame count", 64'(frames_seen), 64'(exp_frames));
    chk(sck_idle_bad == 0, "R11 sck low while deselected", 64'(sck_idle_bad), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule